// File: doc/BRIEF.md
# Display Frame Fetch Address Walker

This block walks the memory addresses that a display refresh engine reads for one frame. The frame is stored as a virtual screen that may be wider than the visible viewport. Each visible line is fetched as a run of 32-bit words. Between the last word of one line and the first word of the next, a programmable gap of half-words is skipped. All addresses are half-word addresses: a fixed bank field sits above a half-word offset, and only the offset moves during a frame.

A frame-start pulse latches the geometry and loads the start address. From then on, every accepted fetch-advance moves the address on by one word, or by one word plus the gap at the end of a line. The block also computes the frame end address from the geometry and raises an end flag when the walk reaches it. A separate one-stage path reorders the byte lanes of each fetched word, with one control that swaps bytes inside half-words and another that swaps half-words.

Top module: `fbuf_addr_gen`

## Requirements
- R1: After reset, fetch_addr is 0, fetch_valid, line_last and frame_end are 0, and lane_word is 0.
- R2: A frame_start pulse latches bank, start, width, offset and line count. In the next cycle fetch_addr equals {cfg_bank, cfg_start}, fetch_valid is 1 and frame_end is 0. frame_start overrides fetch_adv in the same cycle, and it restarts a frame that is still running.
- R3: While fetch_valid is 1, a fetch_adv on a word that is not the last of its line adds 2 to the half-word address, visible one cycle later. Without fetch_adv the address holds.
- R4: Each line holds ceil(cfg_width/2) words, and a width of 0 counts as one word. A fetch_adv on the last word of a line adds 2 + the latched offset.
- R5: line_last is 1 exactly while fetch_valid is 1 and the current address is the last word of a line.
- R6: frame_end rises in the cycle when the address reaches start + (2*words + offset) * (cfg_lineval + 1), modulo 2^21, and fetch_valid falls in that same cycle. frame_end stays at 1 until the next frame_start. The product must be below 2^21.
- R7: While fetch_valid is 0, fetch_adv has no effect: fetch_addr and frame_end hold.
- R8: The bank field of fetch_addr (bits 29:21) keeps its latched value for the whole frame. The half-word field (bits 20:0) wraps modulo 2^21 without carrying into the bank. Configuration inputs changed mid-frame have no effect.
- R9: lane_word is rd_word registered once, with its bytes written b3 b2 b1 b0 from the top. It is reordered by {swap_half, swap_byte}: 00 gives b3 b2 b1 b0, 01 gives b2 b3 b0 b1, 10 gives b1 b0 b3 b2, and 11 gives b0 b1 b2 b3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse: latch geometry and load start address |
| fetch_adv | input | 1 | Current fetch accepted, advance to next word |
| cfg_bank | input | 9 | Fixed upper bank field |
| cfg_start | input | 21 | Frame start, half-word address |
| cfg_width | input | 11 | Visible line width in half-words |
| cfg_offset | input | 11 | Half-words skipped between lines |
| cfg_lineval | input | 10 | Number of lines minus one |
| swap_byte | input | 1 | Swap bytes inside each half-word |
| swap_half | input | 1 | Swap half-words inside each word |
| rd_word | input | 32 | Fetched data word |
| fetch_addr | output | 30 | {bank, half-word address} of the current fetch |
| fetch_valid | output | 1 | Frame walk in progress |
| line_last | output | 1 | Current fetch is last word of its line |
| frame_end | output | 1 | End address reached |
| lane_word | output | 32 | Reordered data word |

## Verification
A word counter that is off by one moves the line-end gap to the wrong word. This shows up at the first line end of a frame, as a wrong fetch_addr and a misplaced line_last, no later than one line into the frame. A wrong end address either leaves fetch_valid high after the last word, or drops it early with frame_end set at an address different from the formula; both are visible at the final advance. A bank register that follows the inputs, or an address carry into the bank, shows up the first time the sweep scrambles the configuration mid-frame or walks a frame across the top of the half-word range.

// File: rtl/fbag_pkg.sv
package fbag_pkg;
  typedef enum logic [1:0] {
    LANE_PASS = 2'b00,
    LANE_BYTE = 2'b01,
    LANE_HALF = 2'b10,
    LANE_REV  = 2'b11
  } lane_mode_e;
endpackage

// File: rtl/fbag_geom.sv
module fbag_geom #(
  parameter int AW = 21,
  parameter int SW = 11,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] cfg_start,
  input  logic [SW-1:0] cfg_width,
  input  logic [SW-1:0] cfg_offset,
  input  logic [LW-1:0] cfg_lineval,
  output logic [SW-1:0] words_q,
  output logic [SW-1:0] offset_q,
  output logic [AW-1:0] end_q
);
  localparam int PW = SW + 2 + LW + 1;
  localparam int XW = (PW > AW) ? PW : AW;

  logic [SW:0]   wsum_c;
  logic [SW-1:0] words_c;
  logic [SW+1:0] span_c;
  logic [LW:0]   lines_c;
  logic [PW-1:0] prod_c;
  logic [XW-1:0] sum_c;

  always_comb begin
    wsum_c  = {1'b0, cfg_width} + (SW+1)'(1);
    words_c = wsum_c[SW:1];
    if (words_c == '0) words_c = SW'(1);
    span_c  = (SW+2)'({words_c, 1'b0}) + (SW+2)'(cfg_offset);
    lines_c = {1'b0, cfg_lineval} + (LW+1)'(1);
    prod_c  = PW'(span_c) * PW'(lines_c);
    sum_c   = XW'(cfg_start) + XW'(prod_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      words_q  <= SW'(1);
      offset_q <= '0;
      end_q    <= '0;
    end else if (load) begin
      words_q  <= words_c;
      offset_q <= cfg_offset;
      end_q    <= sum_c[AW-1:0];
    end
  end
endmodule

// File: rtl/fbag_walker.sv
module fbag_walker #(
  parameter int AW = 21,
  parameter int SW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          fetch_adv,
  input  logic [AW-1:0] cfg_start,
  input  logic [SW-1:0] words_q,
  input  logic [SW-1:0] offset_q,
  input  logic [AW-1:0] end_q,
  output logic [AW-1:0] addr_q,
  output logic          valid_q,
  output logic          last_o,
  output logic          done_q
);
  logic [SW-1:0] word_idx_q;
  logic          adv_c;
  logic          at_eol_c;
  logic [AW-1:0] step_c;
  logic [AW-1:0] next_c;

  always_comb begin
    adv_c    = valid_q && fetch_adv && !frame_start;
    at_eol_c = (word_idx_q == words_q - SW'(1));
    step_c   = at_eol_c ? (AW'(offset_q) + AW'(2)) : AW'(2);
    next_c   = addr_q + step_c;
    last_o   = valid_q && at_eol_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      word_idx_q <= '0;
      valid_q    <= 1'b0;
      done_q     <= 1'b0;
    end else if (frame_start) begin
      addr_q     <= cfg_start;
      word_idx_q <= '0;
      valid_q    <= 1'b1;
      done_q     <= 1'b0;
    end else if (adv_c) begin
      addr_q     <= next_c;
      word_idx_q <= at_eol_c ? '0 : word_idx_q + SW'(1);
      if (next_c == end_q) begin
        valid_q <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (valid_q && !done_q && addr_q == $past(cfg_start)));

  a_r3_stride: assert property (@(posedge clk) disable iff (rst)
    (valid_q && fetch_adv && !frame_start && !last_o) |=> (addr_q == $past(addr_q) + AW'(2)));

  a_r4_line_skip: assert property (@(posedge clk) disable iff (rst)
    (valid_q && fetch_adv && !frame_start && last_o)
      |=> (addr_q == $past(addr_q) + AW'(2) + AW'($past(offset_q))));

  a_r6_end_addr: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (addr_q == end_q && !valid_q));

  a_r6_end_sticky: assert property (@(posedge clk) disable iff (rst)
    (done_q && !frame_start) |=> done_q);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && !frame_start) |=> $stable(addr_q));
endmodule

// File: rtl/fbag_lane_swap.sv
module fbag_lane_swap
  import fbag_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap_byte,
  input  logic          swap_half,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout_q
);
  localparam int NHW = DW / 16;
  localparam int NWD = DW / 32;

  logic [DW-1:0] bsw_c, hs_raw_c, hs_bsw_c, sel_c;
  lane_mode_e    mode_c;

  for (genvar g = 0; g < NHW; g++) begin : g_bsw
    assign bsw_c[g*16 +: 16] = {din[g*16 +: 8], din[g*16+8 +: 8]};
  end

  for (genvar p = 0; p < NWD; p++) begin : g_hsw
    assign hs_raw_c[p*32 +: 32] = {din[p*32 +: 16], din[p*32+16 +: 16]};
    assign hs_bsw_c[p*32 +: 32] = {bsw_c[p*32 +: 16], bsw_c[p*32+16 +: 16]};
  end

  always_comb begin
    mode_c = lane_mode_e'({swap_half, swap_byte});
    case (mode_c)
      LANE_BYTE: sel_c = bsw_c;
      LANE_HALF: sel_c = hs_raw_c;
      LANE_REV:  sel_c = hs_bsw_c;
      default:   sel_c = din;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) dout_q <= '0;
    else     dout_q <= sel_c;
  end

  a_r9_pass: assert property (@(posedge clk) disable iff (rst)
    (!swap_byte && !swap_half) |=> (dout_q == $past(din)));

  a_r9_ones_kept: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(dout_q) == $countones($past(din))));
endmodule

// File: rtl/fbuf_addr_gen.sv
module fbuf_addr_gen #(
  parameter int BANK_W  = 9,
  parameter int HADDR_W = 21,
  parameter int SPAN_W  = 11,
  parameter int LINE_W  = 10,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      frame_start,
  input  logic                      fetch_adv,
  input  logic [BANK_W-1:0]         cfg_bank,
  input  logic [HADDR_W-1:0]        cfg_start,
  input  logic [SPAN_W-1:0]         cfg_width,
  input  logic [SPAN_W-1:0]         cfg_offset,
  input  logic [LINE_W-1:0]         cfg_lineval,
  input  logic                      swap_byte,
  input  logic                      swap_half,
  input  logic [DATA_W-1:0]         rd_word,
  output logic [BANK_W+HADDR_W-1:0] fetch_addr,
  output logic                      fetch_valid,
  output logic                      line_last,
  output logic                      frame_end,
  output logic [DATA_W-1:0]         lane_word
);
  logic [BANK_W-1:0]  bank_q;
  logic [SPAN_W-1:0]  words_q, offset_q;
  logic [HADDR_W-1:0] end_q, addr_q;

  always_ff @(posedge clk) begin
    if (rst)              bank_q <= '0;
    else if (frame_start) bank_q <= cfg_bank;
  end

  fbag_geom #(.AW(HADDR_W), .SW(SPAN_W), .LW(LINE_W)) u_geom (
    .clk(clk), .rst(rst), .load(frame_start),
    .cfg_start(cfg_start), .cfg_width(cfg_width),
    .cfg_offset(cfg_offset), .cfg_lineval(cfg_lineval),
    .words_q(words_q), .offset_q(offset_q), .end_q(end_q)
  );

  fbag_walker #(.AW(HADDR_W), .SW(SPAN_W)) u_walk (
    .clk(clk), .rst(rst), .frame_start(frame_start), .fetch_adv(fetch_adv),
    .cfg_start(cfg_start), .words_q(words_q), .offset_q(offset_q),
    .end_q(end_q), .addr_q(addr_q), .valid_q(fetch_valid),
    .last_o(line_last), .done_q(frame_end)
  );

  fbag_lane_swap #(.DW(DATA_W)) u_lane (
    .clk(clk), .rst(rst), .swap_byte(swap_byte), .swap_half(swap_half),
    .din(rd_word), .dout_q(lane_word)
  );

  assign fetch_addr = {bank_q, addr_q};

  a_r8_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(bank_q));
endmodule

// File: tb/fbuf_addr_gen_test.sv
module fbuf_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        fetch_adv = 1'b0;
  logic [8:0]  cfg_bank = '0;
  logic [20:0] cfg_start = '0;
  logic [10:0] cfg_width = '0;
  logic [10:0] cfg_offset = '0;
  logic [9:0]  cfg_lineval = '0;
  logic        swap_byte = 1'b0;
  logic        swap_half = 1'b0;
  logic [31:0] rd_word = '0;
  logic [29:0] fetch_addr;
  logic        fetch_valid, line_last, frame_end;
  logic [31:0] lane_word;

  int vecs = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fbuf_addr_gen uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .fetch_adv(fetch_adv),
    .cfg_bank(cfg_bank), .cfg_start(cfg_start), .cfg_width(cfg_width),
    .cfg_offset(cfg_offset), .cfg_lineval(cfg_lineval),
    .swap_byte(swap_byte), .swap_half(swap_half), .rd_word(rd_word),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .line_last(line_last),
    .frame_end(frame_end), .lane_word(lane_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_model(input logic [31:0] d, input logic sb, input logic sh);
    logic [7:0] b0, b1, b2, b3;
    {b3, b2, b1, b0} = d;
    case ({sh, sb})
      2'b01:   return {b2, b3, b0, b1};
      2'b10:   return {b1, b0, b3, b2};
      2'b11:   return {b0, b1, b2, b3};
      default: return d;
    endcase
  endfunction

  task automatic run_frame(input logic [20:0] st, input int width, input int off,
                           input int lv, input logic [8:0] bank, input bit gaps);
    int words;
    logic [20:0] exp_a, formula;
    words = (width + 1) / 2;
    if (words == 0) words = 1;
    @(negedge clk);
    cfg_start = st; cfg_width = 11'(width); cfg_offset = 11'(off);
    cfg_lineval = 10'(lv); cfg_bank = bank;
    frame_start = 1'b1; fetch_adv = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; fetch_adv = 1'b0;
    // R8: scramble configuration mid-frame
    cfg_bank = ~bank; cfg_start = ~st; cfg_width = 11'h7ff; cfg_offset = 11'h3ff; cfg_lineval = 10'h3ff;
    chk("R2 start addr", 32'(fetch_addr), 32'({bank, st}));
    chk("R2 valid", 32'(fetch_valid), 32'd1);
    chk("R2 end clear", 32'(frame_end), 32'd0);
    exp_a = st;
    for (int l = 0; l <= lv; l++) begin
      for (int w = 0; w < words; w++) begin
        bit fin;
        chk("R5 line_last", 32'(line_last), 32'(w == words - 1));
        if (gaps && (w % 2 == 0)) begin
          @(negedge clk);
          chk("R3 hold without advance", 32'(fetch_addr), 32'({bank, exp_a}));
        end
        fetch_adv = 1'b1;
        @(negedge clk);
        fetch_adv = 1'b0;
        fin = (l == lv) && (w == words - 1);
        if (w == words - 1) begin
          exp_a = exp_a + 21'(2 + off);
          chk("R4 line skip / R8 bank", 32'(fetch_addr), 32'({bank, exp_a}));
        end else begin
          exp_a = exp_a + 21'd2;
          chk("R3 word step / R8 bank", 32'(fetch_addr), 32'({bank, exp_a}));
        end
        chk("R6 frame_end", 32'(frame_end), 32'(fin));
        chk("R6 valid", 32'(fetch_valid), 32'(!fin));
      end
    end
    formula = st + 21'((2 * words + off) * (lv + 1));
    chk("R6 end formula", 32'(fetch_addr[20:0]), 32'(formula));
    chk("R5 no line_last after end", 32'(line_last), 32'd0);
    fetch_adv = 1'b1;
    @(negedge clk);
    fetch_adv = 1'b0;
    chk("R7 ignored advance addr", 32'(fetch_addr), 32'({bank, formula}));
    chk("R7 end sticky", 32'(frame_end), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 addr", 32'(fetch_addr), 32'd0);
    chk("R1 valid", 32'(fetch_valid), 32'd0);
    chk("R1 line_last", 32'(line_last), 32'd0);
    chk("R1 frame_end", 32'(frame_end), 32'd0);
    chk("R1 lane_word", lane_word, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    fetch_adv = 1'b1;
    @(negedge clk);
    fetch_adv = 1'b0;
    chk("R7 advance before any frame", 32'(fetch_addr), 32'd0);

    // sweep of geometry
    for (int s = 0; s < 2; s++)
      for (int wd = 0; wd < 8; wd++)
        for (int oi = 0; oi < 4; oi++)
          for (int li = 0; li < 2; li++) begin
            logic [20:0] st;
            int off;
            st  = (s == 0) ? 21'h000100 : 21'h1ffff8;
            off = (oi == 0) ? 0 : (oi == 1) ? 1 : (oi == 2) ? 4 : 7;
            run_frame(st, wd, off, li * 2, 9'(9'h0a5 + wd + oi), bit'((wd + oi) % 2));
          end

    // R2: restart a running frame
    @(negedge clk);
    cfg_start = 21'h002000; cfg_width = 11'd6; cfg_offset = 11'd3; cfg_lineval = 10'd1; cfg_bank = 9'h011;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; fetch_adv = 1'b1;
    repeat (2) @(negedge clk);
    fetch_adv = 1'b0;
    chk("R3 pre-restart addr", 32'(fetch_addr), 32'({9'h011, 21'h002004}));
    cfg_start = 21'h004000; cfg_width = 11'd2; cfg_bank = 9'h022;
    frame_start = 1'b1; fetch_adv = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; fetch_adv = 1'b0;
    chk("R2 restart addr", 32'(fetch_addr), 32'({9'h022, 21'h004000}));
    chk("R2 restart line_last", 32'(line_last), 32'd1);
    chk("R2 restart end clear", 32'(frame_end), 32'd0);

    // R9 lane reorder sweep
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 6; k++) begin
        logic [31:0] d;
        d = 32'h01234567 * (k + 1) + 32'(k * 32'h10305070);
        rd_word = d; swap_byte = m[0]; swap_half = m[1];
        @(negedge clk);
        chk("R9 lane reorder", lane_word, lane_model(d, m[0], m[1]));
      end
    chk("R9 reverse spot", 32'(lane_model(32'haabbccdd, 1'b1, 1'b1)), 32'hddccbbaa);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule